// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI master from a faster module clock. A single configuration word carries two divisor fields and a mode bit. In linear mode the module clock is divided by an even ratio that grows in steps of two. In power-of-two mode the ratio is a power of two. Both modes have a smallest ratio of 2, so the serial clock never runs faster than half the module clock.

Along with the serial clock, the block produces two one-cycle strobes. One marks the transition that leaves the idle level (the leading edge). The other marks the return to the idle level (the trailing edge). A shift engine uses them to launch and capture data. While the run input is low, the clock rests at the level chosen by the polarity input. The configuration is sampled only during that rest, so a run always uses one consistent divide ratio from start to end.

Top module: `spi_clkdiv`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_stb` and `trail_stb` are all low.
- R2: With `div_cfg[12]` = 1 (linear mode), each half period of `sclk` lasts N+1 module clocks, where N = `div_cfg[7:0]`. The full serial period is therefore 2*(N+1) module clocks.
- R3: With `div_cfg[12]` = 0 (power-of-two mode), each half period lasts 2^M module clocks, where M = `div_cfg[11:8]`. The full serial period is therefore 2^(M+1) module clocks.
- R4: N = 0 in linear mode and M = 0 in power-of-two mode both give a serial period of exactly 2 module clocks, which is the fastest rate.
- R5: In the clock after any edge at which `run_en` is sampled low, `sclk` equals the `cpol` value sampled at that edge, and both strobes are low. The half-period counter is cleared at the same time.
- R6: `div_cfg` and `cpol` are captured only at edges where `run_en` is low. A change to either while running has no effect on the period or on strobe placement until after the next stop.
- R7: The first `sclk` transition after a start follows a full half period: it appears h module clocks after the first edge that samples `run_en` high, where h is the half-period length.
- R8: `lead_stb` is high for exactly the one clock in which `sclk` has just moved away from the captured idle level. `trail_stb` is high for exactly the one clock in which `sclk` has just returned to that level. The two strobes are never high together.
- R9: With `cpol` = 1 the idle level is high, the leading edge is a fall and the trailing edge is a rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | 13 | Configuration word: [7:0] linear divisor N, [11:8] power exponent M, [12] mode (1 linear, 0 power-of-two) |
| run_en | input | 1 | High to run the serial clock, low to rest at the idle level |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-clock strobe in the clock where `sclk` has left its idle level |
| trail_stb | output | 1 | One-clock strobe in the clock where `sclk` has returned to its idle level |

## Verification
The hardest behaviour to reach from the ports is the refusal to adopt new settings during a run. To show it, both the divisor word and the polarity must change mid-run, and the waveform must be seen to keep its old rhythm and edge labelling across the change. The bench starts a run with a short half period, switches to a much longer divisor and flips `cpol` while the run continues, and keeps checking every cycle against the original period. It then stops and restarts, and checks that the new ratio and polarity appear only after the restart. A second scenario stops the clock in the middle of its active phase and restarts it. This confirms that the first half period after a restart is full length and not a remainder of the interrupted count.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

   // Mode bit encoding inside the configuration word
   typedef enum logic {
      DIVMODE_POW2   = 1'b0,
      DIVMODE_LINEAR = 1'b1
   } divmode_e;

   // Default field widths
   localparam int unsigned DEF_LIN_W = 8;
   localparam int unsigned DEF_POW_W = 4;

   // Counter width needed for both schemes
   function automatic int unsigned half_cnt_width(input int unsigned lin_w,
                                                  input int unsigned pow_w);
      int unsigned pw;
      pw = (1 << pow_w) - 1;
      return (lin_w > pw) ? lin_w : pw;
   endfunction

endpackage

// File: rtl/spi_clkdiv_cfg.sv
module spi_clkdiv_cfg
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned LIN_W = DEF_LIN_W,
   parameter int unsigned POW_W = DEF_POW_W,
   parameter int unsigned CNT_W = half_cnt_width(DEF_LIN_W, DEF_POW_W),
   localparam int unsigned CFG_W = LIN_W + POW_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CFG_W-1:0] div_cfg,
   input  logic             cpol,
   output logic [CNT_W-1:0] half_m1,
   output logic             pol_q
);

   localparam int unsigned MODE_BIT = LIN_W + POW_W;

   logic [CFG_W-1:0] cfg_q;
   logic [LIN_W-1:0] lin_div;
   logic [POW_W-1:0] pow_exp;
   divmode_e         mode;
   logic [CNT_W-1:0] pow_mask;
   logic [CNT_W-1:0] lin_ext;

   // Shadow copy: refreshed only while the clock rests
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         pol_q <= 1'b0;
      end else if (!run_en) begin
         cfg_q <= div_cfg;
         pol_q <= cpol;
      end
   end

   assign lin_div = cfg_q[LIN_W-1:0];
   assign pow_exp = cfg_q[MODE_BIT-1:LIN_W];
   assign mode    = divmode_e'(cfg_q[MODE_BIT]);

   // 2^M - 1 as a thermometer mask: bit i set when i < M
   for (genvar gi = 0; gi < CNT_W; gi++) begin : g_pow_mask
      assign pow_mask[gi] = (32'(pow_exp) > gi);
   end

   if (CNT_W > LIN_W) begin : g_lin_pad
      assign lin_ext = {{(CNT_W-LIN_W){1'b0}}, lin_div};
   end else begin : g_lin_flat
      assign lin_ext = lin_div;
   end

   always_comb begin
      unique case (mode)
         DIVMODE_LINEAR: half_m1 = lin_ext;
         default:        half_m1 = pow_mask;
      endcase
   end

   // R6: captured settings frozen while running
   a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> ($stable(cfg_q) && $stable(pol_q)));

endmodule

// File: rtl/spi_clkdiv_count.sv
module spi_clkdiv_count #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] half_m1,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run_en && (cnt_q == half_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_en || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // R2: counter never passes the terminal value
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= half_m1);

   // R5: counter cleared while resting
   a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cnt_q == '0));

   // R7: a run always begins from a cleared count
   a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> (cnt_q == '0));

endmodule

// File: rtl/spi_clkdiv_edge.sv
module spi_clkdiv_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic tick,
   input  logic cpol,
   input  logic pol_q,
   output logic sclk,
   output logic lead_stb,
   output logic trail_stb
);

   logic sclk_q, lead_q, trail_q;
   logic at_idle;

   assign at_idle = (sclk_q == pol_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else if (!run_en) begin
         sclk_q  <= cpol;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else begin
         if (tick) sclk_q <= ~sclk_q;
         lead_q  <= tick && at_idle;
         trail_q <= tick && !at_idle;
      end
   end

   assign sclk      = sclk_q;
   assign lead_stb  = lead_q;
   assign trail_stb = trail_q;

   // R8: strobes are exclusive
   a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_q && trail_q));

   // R8: each strobe coincides with an actual transition
   a_r8_lead_moves: assert property (@(posedge clk) disable iff (!rst_n)
      lead_q |-> (sclk_q != $past(sclk_q)));

   a_r8_trail_moves: assert property (@(posedge clk) disable iff (!rst_n)
      trail_q |-> (sclk_q != $past(sclk_q)));

   // R5: resting level follows polarity, strobes quiet
   a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ((sclk_q == $past(cpol)) && !lead_q && !trail_q));

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned LIN_W = DEF_LIN_W,
   parameter int unsigned POW_W = DEF_POW_W,
   localparam int unsigned CFG_W = LIN_W + POW_W + 1,
   localparam int unsigned CNT_W = half_cnt_width(LIN_W, POW_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] div_cfg,
   input  logic             run_en,
   input  logic             cpol,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);

   if (LIN_W < 1 || LIN_W > 31) begin : g_chk_lin
      $error("spi_clkdiv: LIN_W must lie in 1..31");
   end
   if (POW_W < 1 || POW_W > 5) begin : g_chk_pow
      $error("spi_clkdiv: POW_W must lie in 1..5");
   end

   logic [CNT_W-1:0] half_m1;
   logic             pol_q;
   logic             tick;

   spi_clkdiv_cfg #(
      .LIN_W (LIN_W),
      .POW_W (POW_W),
      .CNT_W (CNT_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .div_cfg (div_cfg),
      .cpol    (cpol),
      .half_m1 (half_m1),
      .pol_q   (pol_q)
   );

   spi_clkdiv_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .half_m1 (half_m1),
      .tick    (tick)
   );

   spi_clkdiv_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .tick      (tick),
      .cpol      (cpol),
      .pol_q     (pol_q),
      .sclk      (sclk),
      .lead_stb  (lead_stb),
      .trail_stb (trail_stb)
   );

endmodule

// File: tb/spi_clkdiv_tb.sv
module spi_clkdiv_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] div_cfg = '0;
   logic        run_en = 1'b0;
   logic        cpol = 1'b0;
   logic        sclk, lead_stb, trail_stb;

   int checks = 0;
   int failures = 0;
   int shown = 0;

   always #2 clk = ~clk;   // 250 MHz

   spi_clkdiv u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_cfg   (div_cfg),
      .run_en    (run_en),
      .cpol      (cpol),
      .sclk      (sclk),
      .lead_stb  (lead_stb),
      .trail_stb (trail_stb)
   );

   function automatic logic [12:0] mk_cfg(input logic lin, input int n, input int m);
      return {lin, 4'(m), 8'(n)};
   endfunction

   task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         if (shown < 20) begin
            shown++;
            $display("FAIL %s {sclk,lead,trail} actual=%b expected=%b at %0t", req, act, exp, $time);
         end
      end
   endtask

   // Walk enabled cycles first..last of a run with half period h
   task automatic wave(input int h, input logic pol, input int first, input int last,
                       input string req);
      for (int i = first; i <= last; i++) begin
         int q;
         int r;
         logic [2:0] e;
         @(negedge clk);
         q = i / h;
         r = i % h;
         e[2] = pol ^ q[0];
         e[1] = (r == 0) && q[0];
         e[0] = (r == 0) && !q[0] && (q > 0);
         check3({sclk, lead_stb, trail_stb}, e, req);
      end
   endtask

   task automatic start_run(input logic [12:0] cfg, input logic pol);
      @(negedge clk);
      div_cfg = cfg;
      cpol    = pol;
      repeat (2) @(negedge clk);
      run_en = 1'b1;
   endtask

   task automatic stop_run(input logic pol, input int hold, input string req);
      @(negedge clk);
      run_en = 1'b0;
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         check3({sclk, lead_stb, trail_stb}, {pol, 2'b00}, req);
      end
   endtask

   task automatic t_reset();
      // R1
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         cpol = 1'b1;
         check3({sclk, lead_stb, trail_stb}, 3'b000, "R1 reset");
      end
      rst_n = 1'b1;
      cpol  = 1'b0;
   endtask

   task automatic t_linear();
      start_run(mk_cfg(1'b1, 5, 9), 1'b0);
      wave(6, 1'b0, 1, 40, "R2 linear N=5 / R7 / R8");
      stop_run(1'b0, 3, "R5 stop");
      start_run(mk_cfg(1'b1, 255, 0), 1'b0);
      wave(256, 1'b0, 1, 1100, "R2 linear N=255");
      stop_run(1'b0, 3, "R5 stop");
   endtask

   task automatic t_pow();
      start_run(mk_cfg(1'b0, 200, 3), 1'b0);
      wave(8, 1'b0, 1, 50, "R3 pow M=3");
      stop_run(1'b0, 3, "R5 stop");
      start_run(mk_cfg(1'b0, 7, 2), 1'b1);
      wave(4, 1'b1, 1, 30, "R3 R9 pow M=2 cpol=1");
      stop_run(1'b1, 3, "R9 idle high");
   endtask

   task automatic t_min();
      start_run(mk_cfg(1'b1, 0, 6), 1'b0);
      wave(1, 1'b0, 1, 12, "R4 linear N=0");
      stop_run(1'b0, 2, "R5 stop");
      start_run(mk_cfg(1'b0, 33, 0), 1'b1);
      wave(1, 1'b1, 1, 12, "R4 pow M=0");
      stop_run(1'b1, 2, "R5 stop");
   endtask

   task automatic t_mode_sel();
      start_run(mk_cfg(1'b1, 2, 1), 1'b0);
      wave(3, 1'b0, 1, 24, "R2 mode bit=1 selects N");
      stop_run(1'b0, 2, "R5 stop");
      start_run(mk_cfg(1'b0, 2, 1), 1'b0);
      wave(2, 1'b0, 1, 24, "R3 mode bit=0 selects M");
      stop_run(1'b0, 2, "R5 stop");
   endtask

   task automatic t_cfg_hold();
      start_run(mk_cfg(1'b1, 1, 0), 1'b0);
      wave(2, 1'b0, 1, 9, "R6 before change");
      div_cfg = mk_cfg(1'b1, 7, 0);
      cpol    = 1'b1;
      wave(2, 1'b0, 10, 30, "R6 change ignored while running");
      stop_run(1'b1, 3, "R5 R6 stop adopts new cpol");
      run_en = 1'b1;
      wave(8, 1'b1, 1, 40, "R6 new settings after restart");
      stop_run(1'b1, 2, "R5 stop");
   endtask

   task automatic t_idle_restart();
      start_run(mk_cfg(1'b1, 3, 0), 1'b0);
      wave(4, 1'b0, 1, 6, "R7 run before interrupt");
      stop_run(1'b0, 10, "R5 stop in active phase");
      run_en = 1'b1;
      wave(4, 1'b0, 1, 20, "R7 full first half after restart");
      stop_run(1'b0, 2, "R5 stop");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_linear();
      t_pow();
      t_min();
      t_mode_sel();
      t_cfg_hold();
      t_idle_restart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule